// File: doc/BRIEF.md
# TFT Panel Timing Generator

This block produces the raster timing that a TFT display panel needs: a divided pixel clock, horizontal and vertical sync pulses, a data-enable that frames the visible area, and a masked pixel data bus. Every length is a static configuration input. A field value of N always gives N+1 units, so a zero still yields one line or one pixel clock. Each frame runs through four vertical phases: sync, back porch, active and front porch. Each line runs through the same four phases in pixel clocks.

The panel clock is an even division of the system clock. Every timing output changes on the system clock edge where the pixel clock ends its high half. A select input decides whether the panel sees the pixel clock rising or falling in the middle of each pixel. Sync, data-enable and pixel data each have their own inversion control. Two-bit phase codes and a down-counting line counter are available for status reads.

Raising the enable starts a frame at the first pixel of vertical sync. Dropping the enable lets the current frame run to its last pixel. The block then parks with every output at its inactive level. Configuration must not change while the block is running.

Top module: `tft_timing_gen`

## Requirements
- R1: One pixel clock period lasts 2×(cfg_clk_div+1) system clocks. With vclk_edge_sel=0, pix_clk is low in the first half of each pixel and high in the second half. With vclk_edge_sel=1 it is the inverse. cfg_clk_div is intended to be at least 1.
- R2: A frame consists of cfg_v_sync+1 sync lines, then cfg_v_back+1 back-porch lines, then cfg_v_active+1 active lines, then cfg_v_front+1 front-porch lines. The vertical phase changes only where a line ends. The raw vsync level is asserted only during the sync lines.
- R3: A line consists of cfg_h_sync+1 sync pixels, then cfg_h_back+1 back-porch pixels, then cfg_h_active+1 active pixels, then cfg_h_front+1 front-porch pixels. The horizontal phase only steps forward by one, wrapping from front porch to sync. The raw hsync level is asserted only during the sync pixels.
- R4: hphase and vphase encode sync as 2'b00, back porch as 2'b01, active as 2'b10 and front porch as 2'b11.
- R5: The raw data-enable level is asserted only when both phases are active (2'b10).
- R6: lines_left equals cfg_v_active minus the index of the current active line, so it reads cfg_v_active on the first active line and 0 on the last. It reads 0 during the vertical front porch. It reads cfg_v_active during sync, back porch and idle.
- R7: hsync, vsync and data_en equal the raw level XOR inv_hsync, inv_vsync and inv_den. pix_out equals pix_in XOR all-ones when inv_data=1 and pix_in otherwise, during data-enable. Outside data-enable pix_out is all zeros.
- R8: pix_start is a single-cycle pulse in the first system clock of every active pixel. A frame gives exactly (cfg_h_active+1)×(cfg_v_active+1) pulses.
- R9: A rising enable while idle starts a frame at pixel 0 of line 0 of vertical sync.
- R10: A falling enable mid-frame lets the frame finish. The block then stops and stays idle while enable is low.
- R11: While idle, each of hsync, vsync and data_en sits at its inversion bit. pix_clk equals vclk_edge_sel, both phases read 2'b00, pix_out is zero and pix_start is low.
- R12: Reset puts the block in the idle state of R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request |
| cfg_clk_div | input | 10 | Pixel clock half-period minus one, in system clocks |
| cfg_v_sync | input | 6 | Vertical sync lines minus one |
| cfg_v_back | input | 8 | Vertical back-porch lines minus one |
| cfg_v_active | input | 10 | Active lines minus one |
| cfg_v_front | input | 8 | Vertical front-porch lines minus one |
| cfg_h_sync | input | 8 | Horizontal sync pixels minus one |
| cfg_h_back | input | 7 | Horizontal back-porch pixels minus one |
| cfg_h_active | input | 11 | Active pixels minus one |
| cfg_h_front | input | 8 | Horizontal front-porch pixels minus one |
| inv_vsync | input | 1 | Invert vsync |
| inv_hsync | input | 1 | Invert hsync |
| inv_den | input | 1 | Invert data_en |
| inv_data | input | 1 | Invert pixel data |
| vclk_edge_sel | input | 1 | Invert pix_clk for falling-edge sampling panels |
| pix_in | input | 16 | Pixel data from the fetch path |
| pix_clk | output | 1 | Panel pixel clock |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| data_en | output | 1 | Data enable |
| pix_out | output | 16 | Pixel data to the panel |
| pix_start | output | 1 | First-cycle strobe of each active pixel |
| hphase | output | 2 | Horizontal phase code |
| vphase | output | 2 | Vertical phase code |
| lines_left | output | 10 | Down-counting active line counter |

## Verification
Some properties are checked on every cycle:
- syncs and data-enable appear only inside their phases;
- the horizontal phase only steps forward;
- the vertical phase moves only where a line wraps;
- lines_left stays within its bound;
- pix_start is a lone pulse inside data-enable.

Only the bench scenarios can show the rest. These are the exact segment lengths, the pixel clock period and the edge placement of pix_clk. They also include the per-pixel value of every output under both polarity settings, the pulse count per frame, and a finished frame followed by a quiet stop after enable falls.

// File: rtl/tft_timing_pkg.sv
`timescale 1ns/1ps
package tft_timing_pkg;

  typedef enum logic [1:0] {
    PH_SYNC   = 2'b00,
    PH_BACK   = 2'b01,
    PH_ACTIVE = 2'b10,
    PH_FRONT  = 2'b11
  } phase_e;

  function automatic phase_e phase_after(phase_e cur);
    logic [1:0] t;
    t = cur;
    t = t + 2'd1;
    return phase_e'(t);
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/tft_pixclk_div.sv
`timescale 1ns/1ps
module tft_pixclk_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_lim,
  output logic             clk_raw,
  output logic             pix_tick,
  output logic             pix_first
);

  logic [DIV_W-1:0] half_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      clk_raw  <= 1'b0;
    end else if (!run) begin
      half_cnt <= '0;
      clk_raw  <= 1'b0;
    end else if (half_cnt == half_lim) begin
      half_cnt <= '0;
      clk_raw  <= ~clk_raw;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  // a pixel ends when the high half expires
  assign pix_tick  = run && (half_cnt == half_lim) && clk_raw;
  assign pix_first = run && (half_cnt == '0) && !clk_raw;

endmodule

// File: rtl/tft_axis_seq.sv
`timescale 1ns/1ps
module tft_axis_seq
  import tft_timing_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                adv,
  input  logic [3:0][CW-1:0]  lims,
  output phase_e              phase,
  output logic [CW-1:0]       cnt,
  output logic                wrap
);

  logic seg_last;

  assign seg_last = (cnt == lims[phase]);
  assign wrap     = seg_last && (phase == PH_FRONT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (clr) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (adv) begin
      if (seg_last) begin
        cnt   <= '0;
        phase <= phase_after(phase);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tft_timing_gen.sv
`timescale 1ns/1ps
module tft_timing_gen
  import tft_timing_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int VS_W  = 6,
  parameter int VB_W  = 8,
  parameter int VA_W  = 10,
  parameter int VF_W  = 8,
  parameter int HS_W  = 8,
  parameter int HB_W  = 7,
  parameter int HA_W  = 11,
  parameter int HF_W  = 8,
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] cfg_clk_div,
  input  logic [VS_W-1:0]  cfg_v_sync,
  input  logic [VB_W-1:0]  cfg_v_back,
  input  logic [VA_W-1:0]  cfg_v_active,
  input  logic [VF_W-1:0]  cfg_v_front,
  input  logic [HS_W-1:0]  cfg_h_sync,
  input  logic [HB_W-1:0]  cfg_h_back,
  input  logic [HA_W-1:0]  cfg_h_active,
  input  logic [HF_W-1:0]  cfg_h_front,
  input  logic             inv_vsync,
  input  logic             inv_hsync,
  input  logic             inv_den,
  input  logic             inv_data,
  input  logic             vclk_edge_sel,
  input  logic [PIX_W-1:0] pix_in,
  output logic             pix_clk,
  output logic             hsync,
  output logic             vsync,
  output logic             data_en,
  output logic [PIX_W-1:0] pix_out,
  output logic             pix_start,
  output logic [1:0]       hphase,
  output logic [1:0]       vphase,
  output logic [VA_W-1:0]  lines_left
);

  localparam int HCW = max4(HS_W, HB_W, HA_W, HF_W);
  localparam int VCW = max4(VS_W, VB_W, VA_W, VF_W);

  logic running, start, stop, clr;
  logic clk_raw, pix_tick, pix_first;
  logic h_wrap, v_wrap, frame_end;
  logic hs_raw, vs_raw, de_raw;
  phase_e h_ph, v_ph;
  logic [HCW-1:0] h_cnt;
  logic [VCW-1:0] v_cnt;
  logic [3:0][HCW-1:0] h_lims;
  logic [3:0][VCW-1:0] v_lims;

  // run control: start from idle, stop only on a frame boundary
  assign start     = enable && !running;
  assign frame_end = pix_tick && h_wrap && v_wrap;
  assign stop      = running && !enable && frame_end;
  assign clr       = start || stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     running <= 1'b0;
    else if (start) running <= 1'b1;
    else if (stop)  running <= 1'b0;
  end

  tft_pixclk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (running),
    .half_lim  (cfg_clk_div),
    .clk_raw   (clk_raw),
    .pix_tick  (pix_tick),
    .pix_first (pix_first)
  );

  assign h_lims = {HCW'(cfg_h_front), HCW'(cfg_h_active), HCW'(cfg_h_back), HCW'(cfg_h_sync)};
  assign v_lims = {VCW'(cfg_v_front), VCW'(cfg_v_active), VCW'(cfg_v_back), VCW'(cfg_v_sync)};

  tft_axis_seq #(.CW(HCW)) u_hseq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .adv   (pix_tick),
    .lims  (h_lims),
    .phase (h_ph),
    .cnt   (h_cnt),
    .wrap  (h_wrap)
  );

  tft_axis_seq #(.CW(VCW)) u_vseq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .adv   (pix_tick && h_wrap),
    .lims  (v_lims),
    .phase (v_ph),
    .cnt   (v_cnt),
    .wrap  (v_wrap)
  );

  assign hs_raw = running && (h_ph == PH_SYNC);
  assign vs_raw = running && (v_ph == PH_SYNC);
  assign de_raw = running && (h_ph == PH_ACTIVE) && (v_ph == PH_ACTIVE);

  always_comb begin
    pix_clk   = clk_raw ^ vclk_edge_sel;
    hsync     = hs_raw ^ inv_hsync;
    vsync     = vs_raw ^ inv_vsync;
    data_en   = de_raw ^ inv_den;
    pix_out   = de_raw ? (pix_in ^ {PIX_W{inv_data}}) : '0;
    pix_start = pix_first && de_raw;
    hphase    = h_ph;
    vphase    = v_ph;
    unique case (v_ph)
      PH_ACTIVE: lines_left = cfg_v_active - v_cnt[VA_W-1:0];
      PH_FRONT:  lines_left = '0;
      default:   lines_left = cfg_v_active;
    endcase
  end

endmodule

// File: rtl/tft_timing_chk.sv
`timescale 1ns/1ps
module tft_timing_chk #(
  parameter int VA_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            inv_hsync,
  input logic            inv_vsync,
  input logic            inv_den,
  input logic [VA_W-1:0] cfg_v_active,
  input logic            hsync,
  input logic            vsync,
  input logic            data_en,
  input logic            pix_start,
  input logic [1:0]      hphase,
  input logic [1:0]      vphase,
  input logic [VA_W-1:0] lines_left
);

  AST_HSYNC_IN_SYNC_PHASE: assert property (@(posedge clk) disable iff (!rst_n) (hsync != inv_hsync) |-> (hphase == 2'b00)); // R3
  AST_VSYNC_IN_SYNC_PHASE: assert property (@(posedge clk) disable iff (!rst_n) (vsync != inv_vsync) |-> (vphase == 2'b00)); // R2
  AST_DEN_BOTH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) (data_en != inv_den) |-> (hphase == 2'b10 && vphase == 2'b10)); // R5
  AST_HPHASE_STEPS_FORWARD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(hphase) |-> (hphase == 2'($past(hphase) + 2'd1))); // R3
  AST_VPHASE_AT_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n) !$stable(vphase) |-> ($past(hphase) == 2'b11 && hphase == 2'b00)); // R2
  AST_LINES_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) lines_left <= cfg_v_active); // R6
  AST_PIX_START_IN_DEN: assert property (@(posedge clk) disable iff (!rst_n) pix_start |-> (data_en != inv_den)); // R8
  AST_PIX_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) pix_start |=> !pix_start); // R8

endmodule

bind tft_timing_gen tft_timing_chk #(.VA_W(VA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .inv_hsync    (inv_hsync),
  .inv_vsync    (inv_vsync),
  .inv_den      (inv_den),
  .cfg_v_active (cfg_v_active),
  .hsync        (hsync),
  .vsync        (vsync),
  .data_en      (data_en),
  .pix_start    (pix_start),
  .hphase       (hphase),
  .vphase       (vphase),
  .lines_left   (lines_left)
);

// File: tb/tb_tft_timing_gen.sv
`timescale 1ns/1ps
module tb_tft_timing_gen;

  localparam logic [15:0] PIXV = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [9:0]  cfg_clk_div = 10'd1;
  logic [5:0]  cfg_v_sync = '0;
  logic [7:0]  cfg_v_back = '0;
  logic [9:0]  cfg_v_active = '0;
  logic [7:0]  cfg_v_front = '0;
  logic [7:0]  cfg_h_sync = '0;
  logic [6:0]  cfg_h_back = '0;
  logic [10:0] cfg_h_active = '0;
  logic [7:0]  cfg_h_front = '0;
  logic inv_vsync = 1'b0, inv_hsync = 1'b0, inv_den = 1'b0, inv_data = 1'b0, vclk_edge_sel = 1'b0;
  logic [15:0] pix_in = PIXV;
  logic pix_clk, hsync, vsync, data_en, pix_start;
  logic [15:0] pix_out;
  logic [1:0] hphase, vphase;
  logic [9:0] lines_left;

  always #2 clk = ~clk;

  tft_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_clk_div(cfg_clk_div),
    .cfg_v_sync(cfg_v_sync), .cfg_v_back(cfg_v_back), .cfg_v_active(cfg_v_active),
    .cfg_v_front(cfg_v_front), .cfg_h_sync(cfg_h_sync), .cfg_h_back(cfg_h_back),
    .cfg_h_active(cfg_h_active), .cfg_h_front(cfg_h_front), .inv_vsync(inv_vsync),
    .inv_hsync(inv_hsync), .inv_den(inv_den), .inv_data(inv_data),
    .vclk_edge_sel(vclk_edge_sel), .pix_in(pix_in), .pix_clk(pix_clk), .hsync(hsync),
    .vsync(vsync), .data_en(data_en), .pix_out(pix_out), .pix_start(pix_start),
    .hphase(hphase), .vphase(vphase), .lines_left(lines_left)
  );

  typedef struct packed {
    logic [1:0]  hp;
    logic [1:0]  vp;
    logic        act;
    logic        hs;
    logic        vs;
    logic        de;
    logic [9:0]  ln;
    logic [15:0] px;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  int ps_count = 0;
  event go, done;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int hlen(int p);
    case (p)
      0: return int'(cfg_h_sync);
      1: return int'(cfg_h_back);
      2: return int'(cfg_h_active);
      default: return int'(cfg_h_front);
    endcase
  endfunction

  function automatic int vlen(int p);
    case (p)
      0: return int'(cfg_v_sync);
      1: return int'(cfg_v_back);
      2: return int'(cfg_v_active);
      default: return int'(cfg_v_front);
    endcase
  endfunction

  // driver: expected per-pixel outputs for one frame, from the requirements
  task automatic push_frame();
    for (int vp = 0; vp < 4; vp++)
      for (int vi = 0; vi <= vlen(vp); vi++)
        for (int hp = 0; hp < 4; hp++)
          for (int hi = 0; hi <= hlen(hp); hi++) begin
            exp_t e;
            e.hp  = 2'(hp);
            e.vp  = 2'(vp);
            e.act = (hp == 2) && (vp == 2);
            e.hs  = (hp == 0) ^ inv_hsync;
            e.vs  = (vp == 0) ^ inv_vsync;
            e.de  = e.act ^ inv_den;
            e.ln  = (vp == 2) ? 10'(int'(cfg_v_active) - vi) : (vp == 3) ? 10'd0 : cfg_v_active;
            e.px  = e.act ? (PIXV ^ {16{inv_data}}) : 16'h0;
            exp_q.push_back(e);
          end
  endtask

  // monitor: one expected item per pixel period, starting at the start edge
  always begin
    @(go);
    while (exp_q.size() > 0) begin
      exp_t e;
      int hper;
      hper = int'(cfg_clk_div) + 1;
      e = exp_q.pop_front();
      @(negedge clk);
      chk("R8", "pix_start in first cycle", pix_start, e.act);
      chk("R1", "pix_clk first half", pix_clk, vclk_edge_sel);
      repeat (hper) @(posedge clk);
      @(negedge clk);
      chk("R1", "pix_clk second half", pix_clk, !vclk_edge_sel);
      chk("R4", "hphase", hphase, e.hp);
      chk("R2", "vphase", vphase, e.vp);
      chk("R3", "hsync", hsync, e.hs);
      chk("R2", "vsync", vsync, e.vs);
      chk("R5", "data_en", data_en, e.de);
      chk("R6", "lines_left", lines_left, e.ln);
      chk("R7", "pix_out", pix_out, e.px);
      repeat (hper) @(posedge clk);
    end
    -> done;
  end

  always @(negedge clk) if (pix_start) ps_count++;

  task automatic check_idle(input string req);
    chk(req, "idle hphase", hphase, 2'b00);
    chk(req, "idle vphase", vphase, 2'b00);
    chk(req, "idle hsync", hsync, inv_hsync);
    chk(req, "idle vsync", vsync, inv_vsync);
    chk(req, "idle data_en", data_en, inv_den);
    chk(req, "idle pix_clk", pix_clk, vclk_edge_sel);
    chk(req, "idle pix_out", pix_out, 16'h0);
    chk(req, "idle pix_start", pix_start, 1'b0);
    chk(req, "idle lines_left", lines_left, cfg_v_active);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R12: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R12");
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check_idle("R11");
    chk("R11", "no pix_start while disabled", ps_count, 0);

    // config 1: normal polarity, two frames, enable falls in the second
    cfg_clk_div = 10'd1;
    cfg_h_sync = 8'd1; cfg_h_back = 7'd1; cfg_h_active = 11'd3; cfg_h_front = 8'd0;
    cfg_v_sync = 6'd0; cfg_v_back = 8'd1; cfg_v_active = 10'd2; cfg_v_front = 8'd1;
    push_frame();
    push_frame();
    ps_count = 0;
    @(negedge clk);
    enable = 1'b1;                         // R9: frame begins at vertical sync
    @(posedge clk);
    -> go;
    repeat (300) @(posedge clk);
    @(negedge clk);
    enable = 1'b0;                         // R10: second frame must complete
    @(done);
    @(negedge clk);
    check_idle("R10");
    repeat (12) @(posedge clk);
    @(negedge clk);
    check_idle("R10");
    chk("R8", "pix_start count two frames", ps_count, 24);

    // config 2: all inversions, falling-edge panel, slower clock, short frame
    cfg_clk_div = 10'd2;
    cfg_h_sync = 8'd0; cfg_h_back = 7'd0; cfg_h_active = 11'd1; cfg_h_front = 8'd2;
    cfg_v_sync = 6'd1; cfg_v_back = 8'd0; cfg_v_active = 10'd0; cfg_v_front = 8'd0;
    inv_hsync = 1'b1; inv_vsync = 1'b1; inv_den = 1'b1; inv_data = 1'b1; vclk_edge_sel = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_idle("R11");
    push_frame();
    ps_count = 0;
    @(negedge clk);
    enable = 1'b1;
    @(posedge clk);
    -> go;
    repeat (3) @(posedge clk);
    @(negedge clk);
    enable = 1'b0;
    @(done);
    @(negedge clk);
    check_idle("R10");
    repeat (20) @(posedge clk);
    @(negedge clk);
    check_idle("R11");
    chk("R8", "pix_start count one frame", ps_count, 2);

    finish_run();
  end

endmodule